// File: doc/BRIEF.md
# Control-In Endpoint Transmit Buffer

This block holds one outgoing packet for a control-in endpoint and sits between the CPU and the serial engine. The CPU loads up to eight bytes through a write-only byte port and then arms the packet with a commit strobe. From that point the serial engine pulls bytes out in order. It can rewind to the first byte when the host does not acknowledge, and it reports the host's acknowledge, which frees the buffer.

An acknowledge sets a sticky transmit-done flag. The CPU clears this flag by writing one to it. An enable input gates the flag onto the interrupt request line. A separate clear strobe empties the buffer in a single cycle. Bytes written past capacity are dropped, and a sticky overflow bit records the loss.

Top module: `ctlin_txbuf`

## Requirements
- R1: After reset the buffer is empty and unarmed: `pkt_armed`, `tx_valid`, `done_flag`, `ovf_flag` and `irq` are 0, and `tx_len` is 0.
- R2: While the buffer is unarmed, each `cpu_wr_en` stores `cpu_wr_data` at the next slot. `pkt_commit` arms the buffer, and `tx_len` becomes the number of bytes stored (0 to DEPTH, with 0 a legal empty packet). A write in the same cycle as the commit is dropped.
- R3: While the buffer is unarmed, a write with DEPTH bytes already stored is dropped and sets `ovf_flag`. The flag stays 1 until `buf_clear`.
- R4: While the buffer is armed, CPU writes and commits are ignored: `tx_len`, the stored bytes and `ovf_flag` stay unchanged.
- R5: While the buffer is armed, `tx_valid` is 1 exactly while bytes remain to be read. `tx_data` shows the current byte, and `tx_rd` advances to the next byte. A `tx_rd` while `tx_valid` is 0 has no effect.
- R6: `tx_retry` while the buffer is armed rewinds read-out to byte 0 in the next cycle. It wins over a `tx_rd` in the same cycle.
- R7: `tx_ack` while the buffer is armed sets `done_flag` and releases the buffer: unarmed, `tx_len` 0, write slot back to 0. A `tx_ack` while the buffer is unarmed is ignored.
- R8: `flag_clr` clears `done_flag`. An accepted acknowledge in the same cycle wins, and the flag stays 1.
- R9: `irq` is 1 exactly when `done_flag` is 1 and `irq_en` is 1.
- R10: `buf_clear` empties and unarms the buffer and clears `ovf_flag` in one cycle. It wins over a same-cycle write, commit, read, retry or acknowledge, and it leaves `done_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | DATA_W | CPU byte to store |
| pkt_commit | input | 1 | Arm the packet for transmission |
| buf_clear | input | 1 | Empty and unarm the buffer |
| flag_clr | input | 1 | Write-one-to-clear for the done flag |
| irq_en | input | 1 | Interrupt enable for the done flag |
| tx_rd | input | 1 | Serial engine takes the current byte |
| tx_retry | input | 1 | NAK or timeout: restart read-out |
| tx_ack | input | 1 | Host acknowledged the packet |
| tx_data | output | DATA_W | Current byte for transmission |
| tx_valid | output | 1 | A byte remains to be sent |
| tx_len | output | $clog2(DEPTH+1) | Length of the armed packet |
| pkt_armed | output | 1 | Packet committed and awaiting acknowledge |
| done_flag | output | 1 | Sticky transmit-done status |
| ovf_flag | output | 1 | Sticky write-overflow status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- the read position never passes the committed length, and the write position never passes capacity;
- the write position is frozen while the buffer is armed;
- a clear leaves the buffer empty;
- a retry lands on byte zero;
- overflow stays set until a clear;
- the done flag rises only after an accepted acknowledge.

Only the bench scenarios can show that bytes come out in the order they were written, with the right values, for every length from empty through overflow. The same holds for the interrupt under both enable settings and for the outcome of simultaneous strobes.

// File: rtl/ctlin_pkg.sv
package ctlin_pkg;
    localparam int CTLIN_DEPTH  = 8;
    localparam int CTLIN_DATA_W = 8;
endpackage

// File: rtl/ctlin_bytes.sv
module ctlin_bytes #(
    parameter int DEPTH  = ctlin_pkg::CTLIN_DEPTH,
    parameter int DATA_W = ctlin_pkg::CTLIN_DATA_W,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ctlin_seq.sv
module ctlin_seq #(
    parameter int DEPTH = ctlin_pkg::CTLIN_DEPTH,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr_en,
    input  logic          pkt_commit,
    input  logic          buf_clear,
    input  logic          flag_clr,
    input  logic          tx_rd,
    input  logic          tx_retry,
    input  logic          tx_ack,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    output logic          armed,
    output logic          valid,
    output logic [PW-1:0] len,
    output logic          done,
    output logic          ovf
);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW-1:0] len;
        logic          armed;
        logic          done;
        logic          ovf;
    } seq_t;

    seq_t st_d, st_q;
    logic ack_ok;
    logic wr_ok;

    always_comb begin
        st_d   = st_q;
        wr_ok  = 1'b0;
        ack_ok = tx_ack && st_q.armed && !buf_clear;
        if (buf_clear) begin
            st_d.wr    = '0;
            st_d.rd    = '0;
            st_d.len   = '0;
            st_d.armed = 1'b0;
            st_d.ovf   = 1'b0;
        end else if (st_q.armed) begin
            if (tx_ack) begin
                st_d.wr    = '0;
                st_d.rd    = '0;
                st_d.len   = '0;
                st_d.armed = 1'b0;
            end else if (tx_retry) begin
                st_d.rd = '0;
            end else if (tx_rd && (st_q.rd < st_q.len)) begin
                st_d.rd = st_q.rd + 1'b1;
            end
        end else begin
            if (pkt_commit) begin
                st_d.armed = 1'b1;
                st_d.len   = st_q.wr;
                st_d.rd    = '0;
            end else if (cpu_wr_en) begin
                if (st_q.wr < FULL) begin
                    wr_ok   = 1'b1;
                    st_d.wr = st_q.wr + 1'b1;
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
        end
        if (ack_ok)        st_d.done = 1'b1;
        else if (flag_clr) st_d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = wr_ok;
    assign mem_waddr = st_q.wr[AW-1:0];
    assign mem_raddr = st_q.rd[AW-1:0];
    assign armed     = st_q.armed;
    assign valid     = st_q.armed && (st_q.rd < st_q.len);
    assign len       = st_q.len;
    assign done      = st_q.done;
    assign ovf       = st_q.ovf;

    AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr <= FULL);                                                   // R3
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rd <= st_q.len);                                               // R5
    AST_ARMED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !buf_clear && !tx_ack) |=> $stable(st_q.wr));        // R4
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |=> (!st_q.armed && st_q.wr == '0 && st_q.rd == '0));     // R10
    AST_RETRY_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && tx_retry && !tx_ack && !buf_clear) |=> st_q.rd == '0); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !buf_clear) |=> st_q.ovf);                             // R3
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(tx_ack && st_q.armed && !buf_clear));    // R7
endmodule

// File: rtl/ctlin_txbuf.sv
module ctlin_txbuf #(
    parameter int DEPTH  = ctlin_pkg::CTLIN_DEPTH,
    parameter int DATA_W = ctlin_pkg::CTLIN_DATA_W,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              pkt_commit,
    input  logic              buf_clear,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              tx_rd,
    input  logic              tx_retry,
    input  logic              tx_ack,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic [PW-1:0]     tx_len,
    output logic              pkt_armed,
    output logic              done_flag,
    output logic              ovf_flag,
    output logic              irq
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;

    ctlin_seq #(.DEPTH(DEPTH)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .pkt_commit(pkt_commit),
        .buf_clear(buf_clear), .flag_clr(flag_clr),
        .tx_rd(tx_rd), .tx_retry(tx_retry), .tx_ack(tx_ack),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_raddr(mem_raddr),
        .armed(pkt_armed), .valid(tx_valid), .len(tx_len),
        .done(done_flag), .ovf(ovf_flag)
    );

    ctlin_bytes #(.DEPTH(DEPTH), .DATA_W(DATA_W)) bytes_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(cpu_wr_data),
        .raddr(mem_raddr), .rdata(tx_data)
    );

    assign irq = done_flag & irq_en;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done_flag |-> !irq);                                               // R9
    AST_VALID_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> pkt_armed);                                            // R5
endmodule

// File: tb/ctlin_txbuf_tb_top.sv
module ctlin_txbuf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_wr_en = 0, pkt_commit = 0, buf_clear = 0, flag_clr = 0;
    logic irq_en = 0, tx_rd = 0, tx_retry = 0, tx_ack = 0;
    logic [7:0] cpu_wr_data = '0;
    logic [7:0] tx_data;
    logic [3:0] tx_len;
    logic tx_valid, pkt_armed, done_flag, ovf_flag, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlin_txbuf dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .pkt_commit(pkt_commit), .buf_clear(buf_clear), .flag_clr(flag_clr),
        .irq_en(irq_en), .tx_rd(tx_rd), .tx_retry(tx_retry), .tx_ack(tx_ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_len(tx_len),
        .pkt_armed(pkt_armed), .done_flag(done_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: inputs already set at a falling edge, settle to the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cpu_wr_en = 0; pkt_commit = 0; buf_clear = 0; flag_clr = 0;
        tx_rd = 0; tx_retry = 0; tx_ack = 0;
    endtask

    function automatic logic [7:0] pat(input int n, input int i);
        return 8'(n * 37 + i * 11 + 3);
    endfunction

    task automatic write_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_wr_en = 1; cpu_wr_data = pat(n, i); tick();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 armed", pkt_armed, 0);
        chk("R1 valid", tx_valid, 0);
        chk("R1 done", done_flag, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 len", tx_len, 0);

        // sweep packet lengths 0..10 under both enable settings
        for (int en = 0; en < 2; en++) begin
            for (int n = 0; n <= DEPTH + 2; n++) begin
                int exp_len;
                exp_len = (n > DEPTH) ? DEPTH : n;
                irq_en = en[0];
                write_bytes(n);
                chk("R3 ovf", ovf_flag, (n > DEPTH) ? 1 : 0);
                pkt_commit = 1; tick();
                chk("R2 armed", pkt_armed, 1);
                chk("R2 len", tx_len, exp_len);
                for (int i = 0; i < exp_len; i++) begin
                    chk("R5 valid", tx_valid, 1);
                    chk("R5 data", tx_data, pat(n, i));
                    if (i == 1) begin
                        tx_retry = 1; tx_rd = 1; tick();
                        chk("R6 rewind", tx_data, pat(n, 0));
                        tx_rd = 1; tick();
                        chk("R6 reread", tx_data, pat(n, 1));
                    end
                    tx_rd = 1; tick();
                end
                chk("R5 drained", tx_valid, 0);
                tx_rd = 1; tick();
                chk("R5 rd ignored", tx_valid, 0);
                chk("R5 armed kept", pkt_armed, 1);
                tx_ack = 1; tick();
                chk("R7 done", done_flag, 1);
                chk("R7 released", pkt_armed, 0);
                chk("R7 len0", tx_len, 0);
                chk("R9 irq", irq, en);
                flag_clr = 1; tick();
                chk("R8 clr", done_flag, 0);
                chk("R9 irq off", irq, 0);
                buf_clear = 1; tick();
                chk("R10 ovf cleared", ovf_flag, 0);
            end
        end

        // R4: writes and commits while armed are ignored
        write_bytes(3);
        pkt_commit = 1; tick();
        cpu_wr_en = 1; cpu_wr_data = 8'hEE; tick();
        cpu_wr_en = 1; pkt_commit = 1; cpu_wr_data = 8'hEF; tick();
        chk("R4 len", tx_len, 3);
        chk("R4 ovf", ovf_flag, 0);
        chk("R4 byte0", tx_data, pat(3, 0));

        // R10: clear wins over ack, done untouched
        buf_clear = 1; tx_ack = 1; tick();
        chk("R10 unarmed", pkt_armed, 0);
        chk("R10 len", tx_len, 0);
        chk("R10 done kept", done_flag, 0);

        // R7: ack while unarmed ignored
        tx_ack = 1; tick();
        chk("R7 stray ack", done_flag, 0);

        // R2: write in the same cycle as commit dropped; zero slot reused after clear
        write_bytes(2);
        cpu_wr_en = 1; cpu_wr_data = 8'h77; pkt_commit = 1; tick();
        chk("R2 same-cycle write", tx_len, 2);

        // R8: ack wins over flag clear
        irq_en = 1;
        tx_ack = 1; flag_clr = 1; tick();
        chk("R8 ack wins", done_flag, 1);
        chk("R9 irq on", irq, 1);
        irq_en = 0; #1;
        chk("R9 gated", irq, 0);

        // R10: clear wins over commit, keeps done set
        write_bytes(4);
        buf_clear = 1; pkt_commit = 1; tick();
        chk("R10 commit lost", pkt_armed, 0);
        chk("R10 done kept set", done_flag, 1);
        pkt_commit = 1; tick();
        chk("R10 empty packet", tx_len, 0);
        chk("R2 empty valid", tx_valid, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule